// File: doc/BRIEF.md
# UART Modem and Line Status Registers

This block keeps the two status registers of a PC-style serial port that report on the outside world: the modem status register and the line status register. It samples the four modem input pins through a synchronizer. It shows their present levels and sets a sticky change flag for each one. Carrier, data-set-ready and clear-to-send flag any edge. The ring input flags only the end of a ring, when it goes from high to low. Error pulses from the receiver set the overrun, parity, framing and break flags, which also stay set. The data-ready flag follows the receiver's data-available signal. The block raises three requests for the interrupt identifier: modem status, line status and receive data.

Reading a register has side effects, and the host bus signals each read with a one-cycle strobe. A modem status read returns the register and then clears the four change flags. A line status read returns the register and then clears the four error flags. A receive data read drops data-ready for one cycle, after which it returns if more bytes are still waiting.

The loop-back control bit in the modem control value changes two things. The modem outputs replace the modem input pins, and the transmit serial stream is turned back into the receive path while the outgoing line idles high.

Top module: `uart_modem_line_status`

## Requirements
- R1: After reset, modem status reads 0x00, line status bits 4:0 read 0, and all three interrupt requests are low.
- R2: A modem pin change appears in the level field, which is bits 7:4 ordered DCD, RI, DSR, CTS from bit 7 down, two clock edges after the pin changes.
- R3: On any edge of DCD, DSR or CTS, the matching change bit (bit 3, bit 1 or bit 0) sets one edge after the level changes. It stays set until the modem status register is read.
- R4: The ring change bit (bit 2) sets only when the ring level goes from 1 to 0. A rising ring level leaves it clear.
- R5: The modem-status request is high whenever any of bits 3:0 is set. The edge that ends a modem status read strobe clears bits 3:0 and the request, and leaves bits 7:4 unchanged.
- R6: Receiver pulses for overrun, parity, framing and break set line status bits 1, 2, 3 and 4, which stay set and raise the line-status request. The edge that ends a line status read strobe clears bits 4:1 and the request.
- R7: An error pulse in the same cycle as a line status read strobe leaves its bit set after the read.
- R8: Line status bit 0 (data ready) and the receive request follow the data-available input one edge later. A receive data read strobe forces them low for one cycle, after which they return if data is still available.
- R9: Line status bits 5, 6 and 7 show the holding-register-empty, transmitter-empty and receive-FIFO-error inputs directly.
- R10: When modem control bit 4 is set, the levels come from modem control bits: DTR (bit 0) to DSR, RTS (bit 1) to CTS, OUT1 (bit 2) to RI and OUT2 (bit 3) to DCD. They show in bits 7:4 with no synchronizer delay, and the modem input pins are ignored.
- R11: With modem control bit 4 set, the receive core input equals the transmit core output and the transmit line is held at 1. With bit 4 clear, the receive core input equals the receive line and the transmit line equals the transmit core output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctsPin | input | 1 | Clear-to-send pin, asynchronous |
| dsrPin | input | 1 | Data-set-ready pin, asynchronous |
| riPin | input | 1 | Ring indicator pin, asynchronous |
| dcdPin | input | 1 | Carrier detect pin, asynchronous |
| mcrBits | input | 5 | Modem control value: DTR, RTS, OUT1, OUT2, loop-back (bits 0 to 4) |
| rxOverrun | input | 1 | Overrun pulse from the receiver |
| rxParityErr | input | 1 | Parity error pulse |
| rxFrameErr | input | 1 | Framing error pulse |
| rxBreak | input | 1 | Break detected pulse |
| rxAvail | input | 1 | Received data waiting |
| rxFifoErr | input | 1 | Receive FIFO holds an errored byte |
| thrEmpty | input | 1 | Transmit holding register empty |
| txEmpty | input | 1 | Transmitter fully idle |
| rdMsr | input | 1 | Modem status read strobe |
| rdLsr | input | 1 | Line status read strobe |
| rdRbr | input | 1 | Receive data read strobe |
| txCore | input | 1 | Serial output of the transmit shifter |
| rxLine | input | 1 | Serial receive line from outside |
| msrOut | output | 8 | Modem status register value |
| lsrOut | output | 8 | Line status register value |
| msIrq | output | 1 | Modem-status interrupt request |
| lsIrq | output | 1 | Line-status interrupt request |
| rxIrq | output | 1 | Receive-data interrupt request |
| rxCore | output | 1 | Serial input to the receive shifter |
| txLine | output | 1 | Serial transmit line to outside |

## Verification
A wrong synchronizer or previous-level register shows up within three edges of a pin change. It appears as a missing or spurious change bit in msrOut, and most clearly as a ring flag on the rising edge instead of the falling one. A broken sticky or clear path shows up at the first status read: the bits either survive the edge that ends the strobe or are gone before the next event. A clear that beats a same-cycle error shows up on the edge right after the read. A wrong loop-back mapping shows up at once in bits 7:4, because that path has no delay.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int MCR_DTR  = 0;
  localparam int MCR_RTS  = 1;
  localparam int MCR_OUT1 = 2;
  localparam int MCR_OUT2 = 3;
  localparam int MCR_LOOP = 4;

  // modem level vector order: {dcd, ri, dsr, cts}
  localparam int LVL_CTS = 0;
  localparam int LVL_DSR = 1;
  localparam int LVL_RI  = 2;
  localparam int LVL_DCD = 3;

  typedef struct packed {
    logic clrDelta;
    logic clrErr;
    logic clrReady;
    logic loopSel;
  } mlsStrobe_t;
endpackage

// File: rtl/mls_ctrl.sv
module mls_ctrl
  import mls_pkg::*;
(
  input  logic       rdMsr,
  input  logic       rdLsr,
  input  logic       rdRbr,
  input  logic [4:0] mcrBits,
  input  logic       txCore,
  input  logic       rxLine,
  output mlsStrobe_t strobe,
  output logic [3:0] loopLevels,
  output logic       rxCore,
  output logic       txLine
);
  always_comb begin
    strobe.clrDelta = rdMsr;
    strobe.clrErr   = rdLsr;
    strobe.clrReady = rdRbr;
    strobe.loopSel  = mcrBits[MCR_LOOP];
  end

  always_comb begin
    loopLevels          = '0;
    loopLevels[LVL_CTS] = mcrBits[MCR_RTS];
    loopLevels[LVL_DSR] = mcrBits[MCR_DTR];
    loopLevels[LVL_RI]  = mcrBits[MCR_OUT1];
    loopLevels[LVL_DCD] = mcrBits[MCR_OUT2];
  end

  assign rxCore = mcrBits[MCR_LOOP] ? txCore : rxLine;
  assign txLine = mcrBits[MCR_LOOP] ? 1'b1   : txCore;
endmodule

// File: rtl/mls_datapath.sv
module mls_datapath
  import mls_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MODEM_W     = 4,
  parameter int ERR_W       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MODEM_W-1:0] pins,
  input  logic [MODEM_W-1:0] loopLevels,
  input  mlsStrobe_t         strobe,
  input  logic [ERR_W-1:0]   errPulse,
  input  logic               rxAvail,
  input  logic               thrEmpty,
  input  logic               txEmpty,
  input  logic               rxFifoErr,
  output logic [7:0]         msr,
  output logic [7:0]         lsr,
  output logic               msIrq,
  output logic               lsIrq,
  output logic               rxIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [MODEM_W-1:0] syncQ [SYNC_STAGES];
  logic [MODEM_W-1:0] lvl, prevLvl, evt, delta;
  logic [ERR_W-1:0]   err;
  logic               ready;

  // pin synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= pins;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign lvl = strobe.loopSel ? loopLevels : syncQ[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= lvl;
  end

  // change events: ring flags only the trailing edge
  for (genvar b = 0; b < MODEM_W; b++) begin : g_evt
    if (b == LVL_RI) begin : g_ring
      assign evt[b] = prevLvl[b] & ~lvl[b];
    end else begin : g_any
      assign evt[b] = prevLvl[b] ^ lvl[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) delta <= '0;
    else       delta <= (strobe.clrDelta ? '0 : delta) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) err <= '0;
    else       err <= (strobe.clrErr ? '0 : err) | errPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ready <= 1'b0;
    else       ready <= strobe.clrReady ? 1'b0 : rxAvail;
  end

  assign msr   = {lvl, delta};
  assign lsr   = {rxFifoErr, txEmpty, thrEmpty, err, ready};
  assign msIrq = |delta;
  assign lsIrq = |err;
  assign rxIrq = ready;

  // R5: a read with no new event leaves no change bit behind
  a_r5_delta_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrDelta && evt == '0) |=> (delta == '0));

  // R6: a read with no new error leaves no error bit behind
  a_r6_err_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrErr && errPulse == '0) |=> (err == '0));

  // R7: every error pulse is present in the register afterwards
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rstN)
    (|errPulse) |=> ((err & $past(errPulse)) == $past(errPulse)));

  // R8: a receive data read drops data ready
  a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrReady |=> !ready);

  // R4: ring flag appears only after a high-to-low ring level
  a_r4_ri_trailing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delta[LVL_RI]) |-> ($past(lvl[LVL_RI]) == 1'b0 && $past(prevLvl[LVL_RI]) == 1'b1));
endmodule

// File: rtl/uart_modem_line_status.sv
module uart_modem_line_status
  import mls_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsPin,
  input  logic       dsrPin,
  input  logic       riPin,
  input  logic       dcdPin,
  input  logic [4:0] mcrBits,
  input  logic       rxOverrun,
  input  logic       rxParityErr,
  input  logic       rxFrameErr,
  input  logic       rxBreak,
  input  logic       rxAvail,
  input  logic       rxFifoErr,
  input  logic       thrEmpty,
  input  logic       txEmpty,
  input  logic       rdMsr,
  input  logic       rdLsr,
  input  logic       rdRbr,
  input  logic       txCore,
  input  logic       rxLine,
  output logic [7:0] msrOut,
  output logic [7:0] lsrOut,
  output logic       msIrq,
  output logic       lsIrq,
  output logic       rxIrq,
  output logic       rxCore,
  output logic       txLine
);
  mlsStrobe_t strobe;
  logic [3:0] loopLevels;

  mls_ctrl ctrl_i (
    .rdMsr(rdMsr), .rdLsr(rdLsr), .rdRbr(rdRbr), .mcrBits(mcrBits),
    .txCore(txCore), .rxLine(rxLine), .strobe(strobe),
    .loopLevels(loopLevels), .rxCore(rxCore), .txLine(txLine)
  );

  mls_datapath #(.SYNC_STAGES(SYNC_STAGES), .MODEM_W(4), .ERR_W(4)) dp_i (
    .clk(clk), .rstN(rstN),
    .pins({dcdPin, riPin, dsrPin, ctsPin}),
    .loopLevels(loopLevels), .strobe(strobe),
    .errPulse({rxBreak, rxFrameErr, rxParityErr, rxOverrun}),
    .rxAvail(rxAvail), .thrEmpty(thrEmpty), .txEmpty(txEmpty),
    .rxFifoErr(rxFifoErr),
    .msr(msrOut), .lsr(lsrOut), .msIrq(msIrq), .lsIrq(lsIrq), .rxIrq(rxIrq)
  );

  // R10: loop-back levels follow the modem control bits
  a_r10_loop_map: assert property (@(posedge clk) disable iff (!rstN)
    mcrBits[MCR_LOOP] |-> (msrOut[7:4] == {mcrBits[MCR_OUT2], mcrBits[MCR_OUT1],
                                          mcrBits[MCR_DTR], mcrBits[MCR_RTS]}));

  // R11: loop-back idles the line and returns the transmit stream
  a_r11_loop_serial: assert property (@(posedge clk) disable iff (!rstN)
    mcrBits[MCR_LOOP] |-> (txLine && rxCore == txCore));
endmodule

// File: tb/uart_modem_line_status_tb_top.sv
`timescale 1ns/1ps
module uart_modem_line_status_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsPin = 0, dsrPin = 0, riPin = 0, dcdPin = 0;
  logic [4:0] mcrBits = '0;
  logic rxOverrun = 0, rxParityErr = 0, rxFrameErr = 0, rxBreak = 0;
  logic rxAvail = 0, rxFifoErr = 0, thrEmpty = 1, txEmpty = 1;
  logic rdMsr = 0, rdLsr = 0, rdRbr = 0, txCore = 1, rxLine = 1;
  logic [7:0] msrOut, lsrOut;
  logic msIrq, lsIrq, rxIrq, rxCore, txLine;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_modem_line_status dut_i (.*);

  // {errMask[3:0] = break,frame,parity,overrun ; thr ; tx ; fifoErr ; expected lsr}
  localparam logic [14:0] LSR_VEC [6] = '{
    {4'b0001, 1'b1, 1'b1, 1'b0, 8'h62},
    {4'b0010, 1'b1, 1'b0, 1'b0, 8'h24},
    {4'b0100, 1'b0, 1'b0, 1'b1, 8'h88},
    {4'b1000, 1'b0, 1'b0, 1'b0, 8'h10},
    {4'b1111, 1'b1, 1'b1, 1'b1, 8'hFE},
    {4'b0000, 1'b1, 1'b1, 1'b0, 8'h60}
  };

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic readMsr(logic [7:0] exp);
    rdMsr = 1;
    chk("R5 read value", msrOut, exp);
    step();
    rdMsr = 0;
  endtask

  initial begin
    step(3);
    rstN = 1;
    step();
    // R1 reset state
    chk("R1 msr", msrOut, 8'h00);
    chk("R1 lsr", lsrOut, 8'h60);
    chk("R1 irqs", {5'b0, msIrq, lsIrq, rxIrq}, 8'h00);

    // R2 / R3 CTS rising
    ctsPin = 1;
    step(2);
    chk("R2 level after two edges", msrOut, 8'h10);
    step();
    chk("R3 cts change", msrOut, 8'h11);
    chk("R5 ms request", {7'b0, msIrq}, 8'h01);
    step(3);
    chk("R3 sticky", msrOut, 8'h11);
    readMsr(8'h11);
    chk("R5 cleared", msrOut, 8'h10);
    chk("R5 request cleared", {7'b0, msIrq}, 8'h00);

    // R4 ring: rising gives nothing, falling flags
    riPin = 1;
    step(4);
    chk("R4 ring rise no flag", msrOut, 8'h50);
    riPin = 0;
    step(4);
    chk("R4 ring trailing flag", msrOut, 8'h14);
    readMsr(8'h14);

    // R3 DSR and DCD both edges
    dsrPin = 1; dcdPin = 1;
    step(4);
    chk("R3 dsr dcd rise", msrOut, 8'hBA);
    readMsr(8'hBA);
    chk("R5 levels kept", msrOut, 8'hB0);
    ctsPin = 0; dsrPin = 0; dcdPin = 0;
    step(4);
    chk("R3 all fall", msrOut, 8'h0B);
    readMsr(8'h0B);
    chk("R5 all clear", msrOut, 8'h00);

    // R6 / R9 vector table
    foreach (LSR_VEC[k]) begin
      logic [14:0] v;
      v = LSR_VEC[k];
      {rxBreak, rxFrameErr, rxParityErr, rxOverrun} = v[14:11];
      thrEmpty = v[10]; txEmpty = v[9]; rxFifoErr = v[8];
      step();
      {rxBreak, rxFrameErr, rxParityErr, rxOverrun} = 4'b0;
      chk("R6 R9 lsr value", lsrOut, v[7:0]);
      chk("R6 ls request", {7'b0, lsIrq}, {7'b0, |v[14:11]});
      rdLsr = 1;
      step();
      rdLsr = 0;
      chk("R6 errors cleared", {3'b0, lsrOut[4:1], lsIrq}, 8'h00);
    end
    thrEmpty = 1; txEmpty = 1; rxFifoErr = 0;

    // R7 error in same cycle as read
    rxParityErr = 1;
    step();
    rxParityErr = 0;
    rdLsr = 1; rxOverrun = 1;
    step();
    rdLsr = 0; rxOverrun = 0;
    chk("R7 overrun survives read", lsrOut, 8'h62);
    rdLsr = 1; step(); rdLsr = 0;

    // R8 data ready
    rxAvail = 1;
    step();
    chk("R8 ready set", {6'b0, lsrOut[0], rxIrq}, 8'h03);
    rdRbr = 1;
    step();
    rdRbr = 0;
    chk("R8 ready dropped", {6'b0, lsrOut[0], rxIrq}, 8'h00);
    step();
    chk("R8 ready returns", {6'b0, lsrOut[0], rxIrq}, 8'h03);
    rxAvail = 0;
    rdRbr = 1;
    step();
    rdRbr = 0;
    step();
    chk("R8 ready stays low", {6'b0, lsrOut[0], rxIrq}, 8'h00);

    // R11 normal routing
    txCore = 0; rxLine = 1;
    #1;
    chk("R11 normal routing", {6'b0, rxCore, txLine}, 8'h02);

    // R10 loop-back
    ctsPin = 1;
    step(4);
    readMsr(8'h11);
    mcrBits = 5'b11001;
    #1;
    chk("R10 immediate levels", {msrOut[7:4], 4'b0}, 8'hA0);
    step();
    chk("R10 loop changes", msrOut, 8'hAB);
    riPin = 1; ctsPin = 0;
    step(4);
    chk("R10 pins ignored", msrOut, 8'hAB);
    // R11 loop-back serial
    txCore = 0; rxLine = 1;
    #1;
    chk("R11 loop tx low", {6'b0, rxCore, txLine}, 8'h01);
    txCore = 1;
    #1;
    chk("R11 loop tx high", {6'b0, rxCore, txLine}, 8'h03);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule